// File: doc/BRIEF.md
# Sticky Interrupt Status and Mask Unit

This block gathers one-cycle event pulses from an audio receiver and transmitter and stores them in status bits that stay set until software clears them. Four further status positions do not latch. They follow live occupancy levels, registered by one clock. Each status bit is ANDed with its own enable bit, and the OR of those products drives one registered interrupt line.

Software reaches the unit through a simple word-addressed bus. The enable register has its own word. Status and clear share a single word: a read there returns the status, and a write there clears every sticky bit written with a one. Level-following bits ignore clear writes. Positions that have no function read as zero and ignore writes. Read data is registered, so it appears one cycle after the address is presented.

Top module: `irq_status_unit`

## Requirements
- R1: After a synchronous reset the status bits, the enable bits, the read data and the interrupt output are all zero.
- R2: A one on a sticky position of `evt_pulse` sets that status bit at the next clock edge. The sticky positions are 2 to 7, 9 and 14 to 20. The bit then stays set while no clear is applied.
- R3: A write to the status word (word address 4) clears each sticky bit whose write-data bit is 1. A bit whose write-data bit is 0 keeps its value.
- R4: When an event pulse and a clear hit the same sticky bit in the same cycle, the bit is set after that edge.
- R5: The level positions 0, 1, 8 and 10 take the value of the same bit of `lvl_in` one cycle later. Clear writes have no effect on them.
- R6: The enable register sits at word address 3 and can be written and read back. Only the positions used in the status map (mask 0x1FC7FF) are stored, and every other position reads 0.
- R7: A read at word address 4 returns the status as it was before the current edge, with unused positions reading 0. Any address other than 3 or 4 reads 0.
- R8: `irq` is 1 exactly one cycle after a cycle in which some status bit and its enable bit are both 1.
- R9: An event pulse on a level or unused position, and a level input on a sticky or unused position, change no status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | ADDR_W | Word address of the access |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for the address presented in the previous cycle |
| evt_pulse | input | 32 | Event pulses, one bit per status position |
| lvl_in | input | 32 | Live level inputs, one bit per status position |
| irq | output | 1 | Registered interrupt line |

## Verification
Directed sequences cover four cases. A lone event followed by a clear with a zero in that bit separates a correct sticky bit from a bit that drops on any write. A clear that arrives together with an event shows whether set has priority over clear. A clear of all ones while the levels are held high separates live bits from sticky ones. Pulses and levels applied on foreign positions show the per-position masking. Next, sparse random event vectors, level changes and writes to random addresses run against a bench model. That phase exercises combinations of enable and status that the directed cases do not reach, and it tests the one-cycle latency of the interrupt and of the read data on every cycle.

// File: rtl/irq_status_pkg.sv
package irq_status_pkg;
  localparam int DATA_W = 32;
  // positions that latch an event until cleared
  localparam logic [DATA_W-1:0] STICKY_MASK = 32'h001F_C2FC;
  // positions that follow a live level
  localparam logic [DATA_W-1:0] LEVEL_MASK  = 32'h0000_0503;
  localparam logic [DATA_W-1:0] USED_MASK   = STICKY_MASK | LEVEL_MASK;
endpackage

// File: rtl/irq_status_bank.sv
module irq_status_bank
  import irq_status_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] evt,
  input  logic [DATA_W-1:0] lvl,
  input  logic              clr_en,
  input  logic [DATA_W-1:0] clr_bits,
  output logic [DATA_W-1:0] stat
);
  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    if (STICKY_MASK[i]) begin : g_sticky
      always_ff @(posedge clk) begin
        if (rst) stat[i] <= 1'b0;
        else if (evt[i]) stat[i] <= 1'b1;
        else if (clr_en && clr_bits[i]) stat[i] <= 1'b0;
      end
      // R2: an event sets the bit
      p_evt_sets_r2: assert property (@(posedge clk) disable iff (rst)
        evt[i] |=> stat[i]);
      // R3: a clear with no event drops the bit
      p_clear_drops_r3: assert property (@(posedge clk) disable iff (rst)
        (clr_en && clr_bits[i] && !evt[i]) |=> !stat[i]);
      // R3: without an event or a clear the bit holds
      p_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (!evt[i] && !(clr_en && clr_bits[i])) |=> $stable(stat[i]));
    end else if (LEVEL_MASK[i]) begin : g_level
      always_ff @(posedge clk) begin
        if (rst) stat[i] <= 1'b0;
        else stat[i] <= lvl[i];
      end
      // R5: the bit follows the level, clear or not
      p_lvl_hi_r5: assert property (@(posedge clk) disable iff (rst)
        lvl[i] |=> stat[i]);
      p_lvl_lo_r5: assert property (@(posedge clk) disable iff (rst)
        !lvl[i] |=> !stat[i]);
    end else begin : g_unused
      assign stat[i] = 1'b0;
    end
  end
endmodule

// File: rtl/irq_enable_reg.sv
module irq_enable_reg
  import irq_status_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] en
);
  always_ff @(posedge clk) begin
    if (rst) en <= '0;
    else if (wr) en <= wdata & USED_MASK;
  end
  // R6: positions outside the map never hold a one
  p_en_unused_r6: assert property (@(posedge clk) disable iff (rst)
    (en & ~USED_MASK) == '0);
endmodule

// File: rtl/irq_combine.sv
module irq_combine
  import irq_status_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] stat,
  input  logic [DATA_W-1:0] en,
  output logic              irq_q
);
  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else irq_q <= |(stat & en);
  end
endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit
  import irq_status_pkg::*;
#(
  parameter int ADDR_W  = 5,
  parameter int EN_WORD = 3,
  parameter int ST_WORD = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [31:0]       evt_pulse,
  input  logic [31:0]       lvl_in,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] EN_A = ADDR_W'(EN_WORD);
  localparam logic [ADDR_W-1:0] ST_A = ADDR_W'(ST_WORD);

  logic [DATA_W-1:0] stat;
  logic [DATA_W-1:0] en;
  logic              wr_en_reg;
  logic              wr_clr;

  assign wr_en_reg = bus_we && (bus_addr == EN_A);
  assign wr_clr    = bus_we && (bus_addr == ST_A);

  irq_status_bank u_bank (
    .clk      (clk),
    .rst      (rst),
    .evt      (evt_pulse),
    .lvl      (lvl_in),
    .clr_en   (wr_clr),
    .clr_bits (bus_wdata),
    .stat     (stat)
  );

  irq_enable_reg u_en (
    .clk   (clk),
    .rst   (rst),
    .wr    (wr_en_reg),
    .wdata (bus_wdata),
    .en    (en)
  );

  irq_combine u_comb (
    .clk   (clk),
    .rst   (rst),
    .stat  (stat),
    .en    (en),
    .irq_q (irq)
  );

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else if (bus_addr == ST_A) bus_rdata <= stat;
    else if (bus_addr == EN_A) bus_rdata <= en;
    else bus_rdata <= '0;
  end

  // R7: unused status positions never read as one
  p_stat_unused_r7: assert property (@(posedge clk) disable iff (rst)
    (stat & ~USED_MASK) == '0);
  // R8: interrupt asserts one cycle after an enabled status bit
  p_irq_rise_r8: assert property (@(posedge clk) disable iff (rst)
    ((stat & en) != '0) |=> irq);
  p_irq_fall_r8: assert property (@(posedge clk) disable iff (rst)
    ((stat & en) == '0) |=> !irq);
  // R7: other addresses read zero
  p_rd_other_r7: assert property (@(posedge clk) disable iff (rst)
    (bus_addr != ST_A && bus_addr != EN_A) |=> bus_rdata == '0);
endmodule

// File: tb/tb_irq_status_unit.sv
module tb_irq_status_unit;
  localparam logic [31:0] STK = 32'h001F_C2FC;
  localparam logic [31:0] LVL = 32'h0000_0503;
  localparam logic [31:0] USD = STK | LVL;
  localparam logic [4:0]  A_EN = 5'd3;
  localparam logic [4:0]  A_ST = 5'd4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [4:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] evt_pulse = '0;
  logic [31:0] lvl_in = '0;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [31:0] m_stat = '0;
  logic [31:0] m_en = '0;

  always #2 clk = ~clk;

  irq_status_unit dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_pulse(evt_pulse),
    .lvl_in(lvl_in), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] rd_model(input logic [4:0] a);
    if (a == A_ST) return m_stat;
    if (a == A_EN) return m_en;
    return 32'h0;
  endfunction

  // one clock: drive at negedge, compare after the edge against the model
  task automatic step(input logic [4:0] a, input logic we, input logic [31:0] wd,
                      input logic [31:0] ev, input logic [31:0] lv);
    logic [31:0] exp_rd;
    logic        exp_irq;
    @(negedge clk);
    bus_addr = a; bus_we = we; bus_wdata = wd; evt_pulse = ev; lvl_in = lv;
    exp_rd  = rd_model(a);
    exp_irq = |(m_stat & m_en);
    @(posedge clk);
    #1;
    m_stat = (m_stat & ~((we && a == A_ST) ? (wd & STK) : 32'h0)) & STK;
    m_stat = m_stat | (ev & STK) | (lv & LVL);
    if (we && a == A_EN) m_en = wd & USD;
    check("R7 read data", bus_rdata, exp_rd);
    check("R8 irq", {31'h0, irq}, {31'h0, exp_irq});
  endtask

  task automatic rd(input logic [4:0] a, input logic [31:0] lv, output logic [31:0] v);
    step(a, 1'b0, 32'h0, 32'h0, lv);
    v = bus_rdata;
  endtask

  initial begin
    logic [31:0] v;
    logic [31:0] lv;
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset rdata", bus_rdata, 32'h0);
    check("R1 reset irq", {31'h0, irq}, 32'h0);
    @(negedge clk); rst = 1'b0;
    rd(A_ST, 0, v); rd(A_ST, 0, v); check("R1 status zero", v, 32'h0);
    rd(A_EN, 0, v); check("R1 enable zero", v, 32'h0);

    // R2: event on bit 5 latches
    step(5'd0, 0, 0, 32'h20, 0);
    rd(A_ST, 0, v); rd(A_ST, 0, v); check("R2 sticky set", v, 32'h20);
    // R3: clear with zero in bit 5 keeps it, clear with one drops it
    step(A_ST, 1, 32'hFFFF_FFDF, 0, 0);
    rd(A_ST, 0, v); rd(A_ST, 0, v); check("R3 write zero keeps", v, 32'h20);
    step(A_ST, 1, 32'h20, 0, 0);
    rd(A_ST, 0, v); rd(A_ST, 0, v); check("R3 write one clears", v, 32'h0);
    // R4: event and clear together
    step(A_ST, 1, 32'h0010_0000, 32'h0010_0000, 0);
    rd(A_ST, 0, v); rd(A_ST, 0, v); check("R4 event wins", v, 32'h0010_0000);
    step(A_ST, 1, 32'hFFFF_FFFF, 0, 0);
    // R5: levels follow and ignore clear
    lv = 32'h503;
    step(5'd0, 0, 0, 0, lv);
    step(A_ST, 1, 32'hFFFF_FFFF, 0, lv);
    rd(A_ST, lv, v); rd(A_ST, lv, v); check("R5 level survives clear", v, 32'h503);
    rd(A_ST, 0, v); rd(A_ST, 0, v); check("R5 level falls", v, 32'h0);
    // R9: foreign positions ignored
    step(5'd0, 0, 0, 32'hFFE0_3D03, 32'hFFFF_FAFC);
    rd(A_ST, 0, v); rd(A_ST, 0, v); check("R9 foreign inputs ignored", v, 32'h0);
    // R6: enable read back masked
    step(A_EN, 1, 32'hFFFF_FFFF, 0, 0);
    rd(A_EN, 0, v); rd(A_EN, 0, v); check("R6 enable masked", v, 32'h001F_C7FF);
    // R7: unused address reads zero
    rd(5'd9, 0, v); rd(5'd9, 0, v); check("R7 other address", v, 32'h0);
    // R8: enabled event raises irq two edges later
    step(5'd0, 0, 0, 32'h4, 0);
    step(5'd0, 0, 0, 0, 0);
    check("R8 irq raised", {31'h0, irq}, 32'h1);
    step(A_ST, 1, 32'h4, 0, 0);
    step(5'd0, 0, 0, 0, 0);
    check("R8 irq dropped", {31'h0, irq}, 32'h0);

    // random phase
    lv = 0;
    for (int k = 0; k < 4000; k++) begin
      logic [4:0] a;
      int sel;
      sel = $urandom_range(0, 9);
      a = (sel < 4) ? A_ST : (sel < 7) ? A_EN : 5'($urandom);
      if ($urandom_range(0, 15) == 0) lv = $urandom;
      step(a, ($urandom_range(0, 3) == 0), $urandom,
           $urandom & $urandom & $urandom & $urandom, lv);
    end
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule